// File: doc/BRIEF.md
# Dual-Channel Two-Phase DMA Engine

This block is a bus master with two independent transfer channels. Each channel holds its own 20-bit source pointer, its own 20-bit destination pointer, a 16-bit transfer count and a small control word. Every transfer takes two bus cycles. The first cycle reads one byte or word from the source into an internal holding register. The second cycle writes that value to the destination. After the write, both pointers advance by a step chosen separately for each of them, and the count drops by one.

Software, or a neighbouring block, fills the channel registers through a simple write port and then pulses the channel's start bit. The engine keeps moving data until the count is used up, and then clears the channel's busy flag. Either end of a transfer may sit in memory space or in I/O space, at an odd or an even address. A strap input limits the engine to 8-bit transfers for narrow-bus builds.

Top module: `dma2_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `bus_req` is 0 and `ch_busy` is all zeros.
- R2: A start pulse sets the channel's busy flag only when its count register is non-zero. A start with a count of zero leaves busy at 0 and produces no bus cycle.
- R3: Every transfer is a read cycle (`bus_write`=0) at the source pointer with `bus_io` set from the source's space bit. It is followed directly by a write cycle (`bus_write`=1) at the destination pointer with `bus_io` set from the destination's space bit. No other bus cycle comes between the two. The write carries the value that was read.
- R4: Control register bits [1:0] and [3:2] set the source and destination step: 00 or 11 holds, 01 increments and 10 decrements. The step is 2 for word transfers and 1 for byte transfers.
- R5: Pointer arithmetic wraps modulo 2^20. For example, FFFFF incremented by 1 gives 00000, and 00000 decremented by 2 gives FFFFE.
- R6: The count decrements once per completed transfer. The channel performs exactly the programmed number of transfers and then clears its busy flag. Busy falls only right after a completed write cycle.
- R7: When both channels are busy, channel 0 wins every arbitration. Channel 1 runs only after channel 0 has finished. A transfer that has started is never interrupted by the other channel.
- R8: When `byte_only` is 1, every bus cycle has `bus_word`=0 and the pointers step by 1, even if the control word bit 6 asks for words.
- R9: On a byte write cycle, `bus_wdata[7:0]` is the low byte that was read and `bus_wdata[15:8]` is 0.
- R10: Once `bus_req` is raised, the address, direction, space and size outputs stay unchanged until a cycle in which both `bus_gnt` and `bus_done` are 1. That edge completes the bus cycle.
- R11: Register writes use `wr_sel` to pick the target: 0 is the source pointer, 1 the destination pointer, 2 the count (`wr_data[15:0]`) and 3 the control word. The control word bits are: 4 = source in I/O space, 5 = destination in I/O space, 6 = word size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_only | input | 1 | Static strap forcing 8-bit transfers |
| wr_en | input | 1 | Register write strobe |
| wr_chan | input | 1 | Channel addressed by the write |
| wr_sel | input | 2 | Register selected by the write |
| wr_data | input | 20 | Register write value |
| start | input | 2 | Per-channel start pulse |
| ch_busy | output | 2 | Per-channel active flag |
| bus_req | output | 1 | Bus cycle requested |
| bus_gnt | input | 1 | Bus granted to this master |
| bus_done | input | 1 | Bus cycle completes at this edge (with grant) |
| bus_addr | output | 20 | Bus address |
| bus_io | output | 1 | 1 = I/O space, 0 = memory space |
| bus_word | output | 1 | 1 = 16-bit cycle, 0 = 8-bit cycle |
| bus_write | output | 1 | 1 = write (deposit), 0 = read (fetch) |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, sampled when the read completes |

## Verification
The hardest case to reach is contention between the channels. Both channels must be busy on the same cycle, so that the fixed priority and the no-interruption rule are actually exercised. The stimulus programs both channels fully and then raises both start bits in a single pulse. The bus log must then show all of channel 0's read/write pairs before any of channel 1's. A slow bus responder that holds off grant for several cycles shows that the request fields stay stable. Pointers placed at the top and bottom of the address space show the wrap.

// File: rtl/dma2_pkg.sv
package dma2_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD  = 2'b00,
        STEP_UP    = 2'b01,
        STEP_DOWN  = 2'b10,
        STEP_HOLDX = 2'b11
    } step_e;

    typedef enum logic [1:0] {
        SEL_SRC  = 2'd0,
        SEL_DST  = 2'd1,
        SEL_CNT  = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_FETCH   = 2'd1,
        PH_DEPOSIT = 2'd2
    } phase_e;

    // bit 6 word, bit 5 dst io, bit 4 src io, bits 3:2 dst step, bits 1:0 src step
    typedef struct packed {
        logic  word;
        logic  dst_io;
        logic  src_io;
        step_e dst_step;
        step_e src_step;
    } chan_ctrl_t;

    localparam int unsigned CTRL_W = $bits(chan_ctrl_t);

endpackage

// File: rtl/dma2_channel.sv
module dma2_channel
    import dma2_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_e          wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              start,
    input  logic              byte_only,
    input  logic              adv,
    output logic [ADDR_W-1:0] src_ptr,
    output logic [ADDR_W-1:0] dst_ptr,
    output chan_ctrl_t        ctrl,
    output logic              eff_word,
    output logic              busy
);

    localparam logic [ADDR_W-1:0] STEP_B = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] STEP_W = ADDR_W'(2);

    logic [CNT_W-1:0] cnt_q;

    function automatic logic [ADDR_W-1:0] advance(
        input logic [ADDR_W-1:0] p,
        input step_e             m,
        input logic              w
    );
        logic [ADDR_W-1:0] d;
        d = w ? STEP_W : STEP_B;
        case (m)
            STEP_UP:   advance = p + d;
            STEP_DOWN: advance = p - d;
            default:   advance = p;
        endcase
    endfunction

    assign eff_word = ctrl.word & ~byte_only;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_ptr <= '0;
            dst_ptr <= '0;
            cnt_q   <= '0;
            ctrl    <= '0;
            busy    <= 1'b0;
        end else begin
            if (adv) begin
                src_ptr <= advance(src_ptr, ctrl.src_step, eff_word);
                dst_ptr <= advance(dst_ptr, ctrl.dst_step, eff_word);
                cnt_q   <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    busy <= 1'b0;
                end
            end
            if (start && !busy && cnt_q != '0) begin
                busy <= 1'b1;
            end
            if (wr_en) begin
                case (wr_sel)
                    SEL_SRC:  src_ptr <= wr_data;
                    SEL_DST:  dst_ptr <= wr_data;
                    SEL_CNT:  cnt_q   <= wr_data[CNT_W-1:0];
                    default:  ctrl    <= chan_ctrl_t'(wr_data[CTRL_W-1:0]);
                endcase
            end
        end
    end

endmodule

// File: rtl/dma2_arbiter.sv
module dma2_arbiter #(
    parameter int NCH   = 2,
    parameter int SEL_W = 1
) (
    input  logic [NCH-1:0]   pend,
    output logic             any,
    output logic [SEL_W-1:0] pick
);

    // lowest index wins
    always_comb begin
        any  = |pend;
        pick = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend[i]) begin
                pick = SEL_W'(i);
            end
        end
    end

endmodule

// File: rtl/dma2_mover.sv
module dma2_mover
    import dma2_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int SEL_W  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pend_any,
    input  logic [SEL_W-1:0]  pick,
    input  logic [ADDR_W-1:0] cur_src,
    input  logic [ADDR_W-1:0] cur_dst,
    input  logic              cur_src_io,
    input  logic              cur_dst_io,
    input  logic              cur_word,
    input  logic              bus_gnt,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [SEL_W-1:0]  sel,
    output logic              adv,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_io,
    output logic              bus_word,
    output logic              bus_write,
    output logic [DATA_W-1:0] bus_wdata
);

    localparam int HALF = DATA_W / 2;

    phase_e            ph_q;
    logic [DATA_W-1:0] hold_q;
    logic              fin;

    assign fin = bus_gnt & bus_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            sel    <= '0;
            hold_q <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    if (pend_any) begin
                        sel  <= pick;
                        ph_q <= PH_FETCH;
                    end
                end
                PH_FETCH: begin
                    if (fin) begin
                        hold_q <= bus_rdata;
                        ph_q   <= PH_DEPOSIT;
                    end
                end
                PH_DEPOSIT: begin
                    if (fin) begin
                        ph_q <= PH_IDLE;
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        bus_req   = (ph_q == PH_FETCH) || (ph_q == PH_DEPOSIT);
        bus_write = (ph_q == PH_DEPOSIT);
        bus_addr  = bus_write ? cur_dst : cur_src;
        bus_io    = bus_write ? cur_dst_io : cur_src_io;
        bus_word  = cur_word;
        adv       = bus_write && fin;
        if (!bus_write) begin
            bus_wdata = '0;
        end else if (cur_word) begin
            bus_wdata = hold_q;
        end else begin
            bus_wdata = {{(DATA_W - HALF){1'b0}}, hold_q[HALF-1:0]};
        end
    end

endmodule

// File: rtl/dma2_ctrl.sv
module dma2_ctrl
    import dma2_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int SEL_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_only,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_chan,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [NCH-1:0]    start,
    output logic [NCH-1:0]    ch_busy,
    output logic              bus_req,
    input  logic              bus_gnt,
    input  logic              bus_done,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_io,
    output logic              bus_word,
    output logic              bus_write,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata
);

    logic [ADDR_W-1:0] src_arr [NCH];
    logic [ADDR_W-1:0] dst_arr [NCH];
    chan_ctrl_t        ctrl_arr[NCH];
    logic [NCH-1:0]    word_arr;
    logic              pend_any;
    logic [SEL_W-1:0]  pick;
    logic [SEL_W-1:0]  sel;
    logic              adv;

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        dma2_channel #(
            .ADDR_W(ADDR_W),
            .CNT_W (CNT_W)
        ) u_ch (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_en && (wr_chan == SEL_W'(i))),
            .wr_sel   (reg_sel_e'(wr_sel)),
            .wr_data  (wr_data),
            .start    (start[i]),
            .byte_only(byte_only),
            .adv      (adv && (sel == SEL_W'(i))),
            .src_ptr  (src_arr[i]),
            .dst_ptr  (dst_arr[i]),
            .ctrl     (ctrl_arr[i]),
            .eff_word (word_arr[i]),
            .busy     (ch_busy[i])
        );
    end

    dma2_arbiter #(
        .NCH  (NCH),
        .SEL_W(SEL_W)
    ) u_arb (
        .pend(ch_busy),
        .any (pend_any),
        .pick(pick)
    );

    dma2_mover #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .SEL_W (SEL_W)
    ) u_mov (
        .clk       (clk),
        .rst       (rst),
        .pend_any  (pend_any),
        .pick      (pick),
        .cur_src   (src_arr[sel]),
        .cur_dst   (dst_arr[sel]),
        .cur_src_io(ctrl_arr[sel].src_io),
        .cur_dst_io(ctrl_arr[sel].dst_io),
        .cur_word  (word_arr[sel]),
        .bus_gnt   (bus_gnt),
        .bus_done  (bus_done),
        .bus_rdata (bus_rdata),
        .sel       (sel),
        .adv       (adv),
        .bus_req   (bus_req),
        .bus_addr  (bus_addr),
        .bus_io    (bus_io),
        .bus_word  (bus_word),
        .bus_write (bus_write),
        .bus_wdata (bus_wdata)
    );

endmodule

// File: rtl/dma2_ctrl_chk.sv
module dma2_ctrl_chk #(
    parameter int NCH    = 2,
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              byte_only,
    input logic [NCH-1:0]    ch_busy,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              bus_done,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_io,
    input logic              bus_word,
    input logic              bus_write,
    input logic [DATA_W-1:0] bus_wdata
);

    localparam int HALF = DATA_W / 2;

    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        $fell(rst) |-> (!bus_req && ch_busy == '0));

    assert_fields_held_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !(bus_gnt && bus_done)) |=>
            (bus_req && $stable(bus_addr) && $stable(bus_write)
             && $stable(bus_io) && $stable(bus_word)));

    assert_deposit_follows_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_write && bus_gnt && bus_done) |=> (bus_req && bus_write));

    assert_byte_upper_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_write && !bus_word) |-> (bus_wdata[DATA_W-1:HALF] == '0));

    assert_narrow_strap_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_req && byte_only) |-> !bus_word);

    for (genvar i = 0; i < NCH; i++) begin : g_end
        assert_busy_ends_on_write_R6: assert property (@(posedge clk) disable iff (rst)
            $fell(ch_busy[i]) |-> $past(bus_req && bus_write && bus_gnt && bus_done));
    end

endmodule

bind dma2_ctrl dma2_ctrl_chk #(
    .NCH   (NCH),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .byte_only(byte_only),
    .ch_busy  (ch_busy),
    .bus_req  (bus_req),
    .bus_gnt  (bus_gnt),
    .bus_done (bus_done),
    .bus_addr (bus_addr),
    .bus_io   (bus_io),
    .bus_word (bus_word),
    .bus_write(bus_write),
    .bus_wdata(bus_wdata)
);

// File: tb/dma2_ctrl_test.sv
`timescale 1ns/1ps
module dma2_ctrl_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        byte_only;
    logic        wr_en;
    logic [0:0]  wr_chan;
    logic [1:0]  wr_sel;
    logic [19:0] wr_data;
    logic [1:0]  start;
    logic [1:0]  ch_busy;
    logic        bus_req;
    logic        bus_gnt;
    logic        bus_done;
    logic [19:0] bus_addr;
    logic        bus_io;
    logic        bus_word;
    logic        bus_write;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;

    int checks = 0;
    int errs   = 0;
    int wait_n = 0;
    int stab_bad = 0;
    int log_n  = 0;
    logic [19:0] log_addr [64];
    logic        log_io   [64];
    logic        log_word [64];
    logic        log_wr   [64];
    logic [15:0] log_data [64];

    always #4 clk = ~clk;

    dma2_ctrl uut (
        .clk(clk), .rst(rst), .byte_only(byte_only), .wr_en(wr_en),
        .wr_chan(wr_chan), .wr_sel(wr_sel), .wr_data(wr_data), .start(start),
        .ch_busy(ch_busy), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .bus_done(bus_done), .bus_addr(bus_addr), .bus_io(bus_io),
        .bus_word(bus_word), .bus_write(bus_write), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    function automatic logic [15:0] model(input logic [19:0] a);
        return {a[7:0], a[15:8]} ^ 16'h5A3C ^ {12'h000, a[19:16]};
    endfunction

    function automatic logic [19:0] bstep(input logic [19:0] p, input int m, input bit w);
        logic [19:0] d;
        d = w ? 20'd2 : 20'd1;
        if (m == 1) return p + d;
        if (m == 2) return p - d;
        return p;
    endfunction

    function automatic logic [19:0] mkctrl(input int sm, input int dm, input bit sio,
                                           input bit dio, input bit w);
        return {13'h0, w, dio, sio, dm[1:0], sm[1:0]};
    endfunction

    // bus responder and transaction log
    initial begin
        bus_gnt = 1'b0;
        bus_done = 1'b0;
        bus_rdata = '0;
        forever begin
            @(negedge clk);
            if (bus_req === 1'b1) begin
                automatic logic [19:0] a0 = bus_addr;
                automatic logic        w0 = bus_write;
                automatic logic        i0 = bus_io;
                automatic logic        s0 = bus_word;
                repeat (wait_n) @(negedge clk);
                if (bus_addr !== a0 || bus_write !== w0 || bus_io !== i0 || bus_word !== s0)
                    stab_bad++;
                bus_rdata = model(bus_addr);
                if (log_n < 64) begin
                    log_addr[log_n] = bus_addr;
                    log_io[log_n]   = bus_io;
                    log_word[log_n] = bus_word;
                    log_wr[log_n]   = bus_write;
                    log_data[log_n] = bus_write ? bus_wdata : bus_rdata;
                end
                log_n++;
                bus_gnt = 1'b1;
                bus_done = 1'b1;
                @(negedge clk);
                bus_gnt = 1'b0;
                bus_done = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wreg(input int ch, input int sel, input logic [19:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_chan = ch[0:0];
        wr_sel = sel[1:0];
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic setup(input int ch, input logic [19:0] s, input logic [19:0] d,
                         input logic [19:0] n, input logic [19:0] c);
        wreg(ch, 0, s);
        wreg(ch, 1, d);
        wreg(ch, 2, n);
        wreg(ch, 3, c);
    endtask

    task automatic go(input logic [1:0] mask);
        @(negedge clk);
        start = mask;
        @(negedge clk);
        start = 2'b00;
    endtask

    task automatic wait_idle();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while ((ch_busy != 2'b00 || bus_req) && n < 3000);
        repeat (4) @(negedge clk);
    endtask

    task automatic check_xfer(input int k, input logic [19:0] s, input bit sio,
                              input logic [19:0] d, input bit dio, input bit w,
                              input string req);
        logic [15:0] md;
        logic [15:0] ed;
        md = model(s);
        ed = w ? md : {8'h00, md[7:0]};
        chk({log_addr[2*k], log_io[2*k], log_word[2*k], log_wr[2*k]} == {s, sio, w, 1'b0},
            {req, " fetch"}, {log_addr[2*k], log_io[2*k], log_word[2*k], log_wr[2*k]},
            {s, sio, w, 1'b0});
        chk({log_addr[2*k+1], log_io[2*k+1], log_word[2*k+1], log_wr[2*k+1]} == {d, dio, w, 1'b1},
            {req, " deposit"}, {log_addr[2*k+1], log_io[2*k+1], log_word[2*k+1], log_wr[2*k+1]},
            {d, dio, w, 1'b1});
        chk(log_data[2*k+1] == ed, {req, " data"}, log_data[2*k+1], ed);
    endtask

    task automatic t_reset();
        chk(bus_req == 1'b0, "R1 bus_req after reset", bus_req, 0);
        chk(ch_busy == 2'b00, "R1 ch_busy after reset", ch_busy, 0);
    endtask

    task automatic t_zero_count();
        log_n = 0;
        setup(0, 20'h00100, 20'h00200, 20'h0, mkctrl(1, 1, 0, 0, 1));
        go(2'b01);
        chk(ch_busy == 2'b00, "R2 zero count start ignored", ch_busy, 0);
        repeat (10) @(negedge clk);
        chk(log_n == 0, "R2 no bus cycle on zero count", log_n, 0);
    endtask

    task automatic t_word_inc_dec();
        logic [19:0] s = 20'h01000;
        logic [19:0] d = 20'h00203;
        log_n = 0;
        setup(0, s, d, 20'd3, mkctrl(1, 2, 0, 1, 1));
        go(2'b01);
        chk(ch_busy == 2'b01, "R2 busy after start", ch_busy, 2'b01);
        wait_idle();
        chk(log_n == 6, "R6 three transfers", log_n, 6);
        for (int k = 0; k < 3; k++) begin
            check_xfer(k, s, 0, d, 1, 1, "R3 R4 word inc/dec");
            s = bstep(s, 1, 1);
            d = bstep(d, 2, 1);
        end
        chk(ch_busy == 2'b00, "R6 busy cleared", ch_busy, 0);
    endtask

    task automatic t_byte_hold();
        logic [19:0] s = 20'h00055;
        logic [19:0] d = 20'h00100;
        log_n = 0;
        setup(1, s, d, 20'd2, mkctrl(0, 1, 1, 0, 0));
        go(2'b10);
        wait_idle();
        chk(log_n == 4, "R6 two byte transfers", log_n, 4);
        for (int k = 0; k < 2; k++) begin
            check_xfer(k, s, 1, d, 0, 0, "R4 R9 byte hold/inc");
            s = bstep(s, 0, 0);
            d = bstep(d, 1, 0);
        end
    endtask

    task automatic t_wrap();
        log_n = 0;
        setup(0, 20'hFFFFF, 20'h00000, 20'd2, mkctrl(1, 2, 0, 0, 0));
        go(2'b01);
        wait_idle();
        check_xfer(0, 20'hFFFFF, 0, 20'h00000, 0, 0, "R5 wrap first");
        check_xfer(1, 20'h00000, 0, 20'hFFFFF, 0, 0, "R5 wrap second");
        log_n = 0;
        setup(0, 20'h00000, 20'hFFFFF, 20'd2, mkctrl(2, 1, 0, 0, 1));
        go(2'b01);
        wait_idle();
        check_xfer(1, 20'hFFFFE, 0, 20'h00001, 0, 1, "R5 word wrap");
    endtask

    task automatic t_priority();
        logic [19:0] s;
        logic [19:0] d;
        log_n = 0;
        setup(1, 20'h40001, 20'h50000, 20'd2, mkctrl(2, 1, 0, 1, 0));
        setup(0, 20'h20000, 20'h30000, 20'd2, mkctrl(1, 0, 0, 0, 1));
        go(2'b11);
        chk(ch_busy == 2'b11, "R7 both busy", ch_busy, 2'b11);
        wait_idle();
        chk(log_n == 8, "R7 four transfers total", log_n, 8);
        s = 20'h20000;
        for (int k = 0; k < 2; k++) begin
            check_xfer(k, s, 0, 20'h30000, 0, 1, "R7 channel 0 first");
            s = bstep(s, 1, 1);
        end
        s = 20'h40001;
        d = 20'h50000;
        for (int k = 2; k < 4; k++) begin
            check_xfer(k, s, 0, d, 1, 0, "R7 channel 1 after");
            s = bstep(s, 2, 0);
            d = bstep(d, 1, 0);
        end
    endtask

    task automatic t_byte_only();
        log_n = 0;
        byte_only = 1'b1;
        setup(0, 20'h00010, 20'h00020, 20'd2, mkctrl(1, 2, 0, 0, 1));
        go(2'b01);
        wait_idle();
        check_xfer(0, 20'h00010, 0, 20'h00020, 0, 0, "R8 forced byte first");
        check_xfer(1, 20'h00011, 0, 20'h0001F, 0, 0, "R8 forced byte step 1");
        byte_only = 1'b0;
    endtask

    task automatic t_slow_bus();
        log_n = 0;
        stab_bad = 0;
        wait_n = 3;
        setup(1, 20'h0ABCD, 20'h0DCBA, 20'd1, mkctrl(1, 1, 1, 0, 1));
        go(2'b10);
        wait_idle();
        wait_n = 0;
        chk(stab_bad == 0, "R10 fields held while stalled", stab_bad, 0);
        chk(log_n == 2, "R10 one transfer under stall", log_n, 2);
        check_xfer(0, 20'h0ABCD, 1, 20'h0DCBA, 0, 1, "R10 R11 stalled transfer");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        byte_only = 1'b0;
        wr_en = 1'b0;
        wr_chan = '0;
        wr_sel = '0;
        wr_data = '0;
        start = '0;
        repeat (4) @(negedge clk);
        chk(bus_req == 1'b0 && ch_busy == 2'b00, "R1 during reset", {bus_req, ch_busy}, 0);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_zero_count();
        t_word_inc_dec();
        t_byte_hold();
        t_wrap();
        t_priority();
        t_byte_only();
        t_slow_bus();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule